// File: doc/BRIEF.md
# Multicore External Interrupt Distributor

A shared distributor that sits between a set of level-sensitive external interrupt lines and several processor cores. Software on any core programs it through a word-addressed register bus. A global enable mask gates the external levels. A global software-assert mask can raise any source regardless of that gate. One routing word per source selects the cores that receive it. Each core gets a registered level vector that merges its routed sources with a three-bit inter-processor vector supplied from outside.

Source index 0 carries no external line and can only be raised by software. Physical lines occupy indices 1 and up. The block also keeps a run-stall word that drives one stall output per core; after reset every core except core 0 is held. It also keeps a one-bit control flag per core, addressed privately by the core that accesses it, and a read-only identity word.

Each core owns a request port and holds its request until it sees its acknowledge. When several cores request in the same cycle, the lowest index wins. The others wait.

Top module: `irq_distributor`

## Requirements
- R1: The routing word of source n is at word offset n for n below NUM_LINES+1. Bit c of that word sends source n to core c. Each routing word resets to 1 and reads back as written, zero-extended.
- R2: Writing offset 0x184 sets every enable bit that is 1 in the data. Writing offset 0x180 clears every enable bit that is 1 in the data. Reading 0x180 returns the enable mask, whose reset value is all ones across the NUM_LINES+1 sources.
- R3: Writing offset 0x18C sets every assert bit that is 1 in the data. Writing offset 0x188 clears every assert bit that is 1 in the data. Reading 0x188 returns the assert mask, whose reset value is zero.
- R4: Core c's vector, coreIrq[c*(NUM_LINES+3) +: NUM_LINES+3], has bit s+2 set when source s is live and routed to c. A source is live when it is enabled and its line is high, or when it is asserted. The vector is ORed with that core's 3-bit ipiVec field in bits 2:0. The vector is registered and follows its inputs after one clock edge.
- R5: An asserted source reaches its routed cores even when its enable bit is clear.
- R6: Source 0 has no external line, so only its assert bit can raise it. Bit 2 of a core's vector is the OR of the source-0 term and ipiVec bit 2.
- R7: Reading offset 0x1A0 returns ((NUM_CORES-1) << 18) OR the index of the requesting core. Writes to it have no effect.
- R8: Offset 0x200 is the run-stall word. Bit c drives coreStall[c] directly from the register. It resets to all ones except bit 0 and reads back as written.
- R9: Offset 0x220 accesses a one-bit control flag private to the requesting core. A write keeps only data bit 0. A read returns that flag in bit 0. The flag resets to 0.
- R10: Reads of unmapped offsets, including 0x184, 0x18C and routing offsets at or beyond NUM_LINES+1, return zero. Writes to those offsets change nothing.
- R11: busAck is one-hot or zero, is set only for a requesting core, and goes to the lowest-index requester in every cycle with any request.
- R12: busRdata carries the read result combinationally in the cycle busAck is high for a read. A write takes effect at the clock edge that ends its acknowledged cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| extLevel | input | NUM_LINES | External levels; bit k is source k+1 |
| ipiVec | input | NUM_CORES*3 | Per-core inter-processor interrupt vector |
| busReq | input | NUM_CORES | Per-core access request, held until acknowledged |
| busWe | input | NUM_CORES | Per-core write select (1 write, 0 read) |
| busAddr | input | NUM_CORES*10 | Per-core word offset |
| busWdata | input | NUM_CORES*32 | Per-core write data |
| busAck | output | NUM_CORES | Access granted this cycle |
| busRdata | output | 32 | Read data of the granted access |
| coreIrq | output | NUM_CORES*(NUM_LINES+3) | Per-core registered interrupt vector |
| coreStall | output | NUM_CORES | Per-core run-stall |

## Verification
A corrupted enable, assert or routing bit stays invisible until some source it governs becomes live. It then shows on the wrong core's vector exactly one edge later, so the bench drives a level pattern that covers every source and compares every vector on every clock. Run-stall and control state show at the ports in the same cycle: one through coreStall, the other through a read. A wrong grant shows at busAck in the cycle of the contest. A write that slips to a neighbouring offset or core shows on the next readback.

// File: rtl/irqd_pkg.sv
package irqd_pkg;
  localparam int ADDR_W = 10;
  localparam int DATA_W = 32;
  localparam int IDX_W  = 5;

  localparam logic [ADDR_W-1:0] OFS_EN_CLR  = 10'h180;
  localparam logic [ADDR_W-1:0] OFS_EN_SET  = 10'h184;
  localparam logic [ADDR_W-1:0] OFS_ASG_CLR = 10'h188;
  localparam logic [ADDR_W-1:0] OFS_ASG_SET = 10'h18C;
  localparam logic [ADDR_W-1:0] OFS_IDENT   = 10'h1A0;
  localparam logic [ADDR_W-1:0] OFS_STALL   = 10'h200;
  localparam logic [ADDR_W-1:0] OFS_CTRL    = 10'h220;

  typedef enum logic [2:0] {
    RD_ZERO, RD_ROUTE, RD_EN, RD_ASG, RD_IDENT, RD_STALL, RD_CTRL
  } rdSel_e;

  typedef struct packed {
    logic              wrRoute;
    logic              enClr;
    logic              enSet;
    logic              asgClr;
    logic              asgSet;
    logic              stallWr;
    logic              ctrlWr;
    logic [IDX_W-1:0]  routeIdx;
    logic [IDX_W-1:0]  coreIdx;
    logic [DATA_W-1:0] wdata;
    rdSel_e            rdSel;
  } strobes_t;
endpackage

// File: rtl/irqd_ctrl.sv
module irqd_ctrl
  import irqd_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int NUM_SRC   = 8
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [NUM_CORES-1:0]        busReq,
  input  logic [NUM_CORES-1:0]        busWe,
  input  logic [NUM_CORES*ADDR_W-1:0] busAddr,
  input  logic [NUM_CORES*DATA_W-1:0] busWdata,
  output logic [NUM_CORES-1:0]        busAck,
  output strobes_t                    stb
);
  logic [NUM_CORES-1:0] grant;
  logic                 found;
  logic                 selWe;
  logic [ADDR_W-1:0]    selAddr;
  logic [DATA_W-1:0]    selWdata;
  logic [IDX_W-1:0]     selIdx;

  // fixed priority: lowest index wins
  always_comb begin
    grant    = '0;
    found    = 1'b0;
    selWe    = 1'b0;
    selAddr  = '0;
    selWdata = '0;
    selIdx   = '0;
    for (int c = 0; c < NUM_CORES; c++) begin
      if (rstN && busReq[c] && !found) begin
        found    = 1'b1;
        grant[c] = 1'b1;
        selIdx   = IDX_W'(c);
        selWe    = busWe[c];
        selAddr  = busAddr[c*ADDR_W +: ADDR_W];
        selWdata = busWdata[c*DATA_W +: DATA_W];
      end
    end
  end

  assign busAck = grant;

  logic isRoute, wrAcc, rdAcc;
  assign isRoute = selAddr < ADDR_W'(NUM_SRC);
  assign wrAcc   = found && selWe;
  assign rdAcc   = found && !selWe;

  always_comb begin
    stb          = '0;
    stb.wdata    = selWdata;
    stb.coreIdx  = selIdx;
    stb.routeIdx = selAddr[IDX_W-1:0];
    stb.wrRoute  = wrAcc && isRoute;
    stb.enClr    = wrAcc && (selAddr == OFS_EN_CLR);
    stb.enSet    = wrAcc && (selAddr == OFS_EN_SET);
    stb.asgClr   = wrAcc && (selAddr == OFS_ASG_CLR);
    stb.asgSet   = wrAcc && (selAddr == OFS_ASG_SET);
    stb.stallWr  = wrAcc && (selAddr == OFS_STALL);
    stb.ctrlWr   = wrAcc && (selAddr == OFS_CTRL);
    stb.rdSel    = RD_ZERO;
    if (rdAcc) begin
      if (isRoute) stb.rdSel = RD_ROUTE;
      else begin
        case (selAddr)
          OFS_EN_CLR:  stb.rdSel = RD_EN;
          OFS_ASG_CLR: stb.rdSel = RD_ASG;
          OFS_IDENT:   stb.rdSel = RD_IDENT;
          OFS_STALL:   stb.rdSel = RD_STALL;
          OFS_CTRL:    stb.rdSel = RD_CTRL;
          default:     stb.rdSel = RD_ZERO;
        endcase
      end
    end
  end

  // R11: at most one grant, only to a requester, core 0 never waits
  p_ack_onehot_r11: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(busAck));
  p_ack_subset_r11: assert property (@(posedge clk) disable iff (!rstN)
    (busAck & ~busReq) == '0);
  p_core0_first_r11: assert property (@(posedge clk) disable iff (!rstN)
    busReq[0] |-> busAck[0]);
  p_some_grant_r11: assert property (@(posedge clk) disable iff (!rstN)
    (busReq != '0) |-> (busAck != '0));
  // R10: a routing write never targets a missing source
  p_route_in_range_r10: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrRoute |-> (32'(stb.routeIdx) < NUM_SRC));
endmodule

// File: rtl/irqd_datapath.sv
module irqd_datapath
  import irqd_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int NUM_LINES = 7,
  localparam int NUM_SRC  = NUM_LINES + 1,
  localparam int IRQ_W    = NUM_SRC + 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  strobes_t                   stb,
  input  logic [NUM_LINES-1:0]       extLevel,
  input  logic [NUM_CORES*3-1:0]     ipiVec,
  output logic [DATA_W-1:0]          rdWord,
  output logic [NUM_CORES*IRQ_W-1:0] coreIrq,
  output logic [NUM_CORES-1:0]       coreStall
);
  logic [NUM_CORES-1:0] routeReg [NUM_SRC];
  logic [NUM_SRC-1:0]   enMask, asgMask, srcLive, wSrc;
  logic [NUM_CORES-1:0] stallReg, ctrlReg, wCore;
  logic [IRQ_W-1:0]     irqReg  [NUM_CORES];
  logic [IRQ_W-1:0]     nextIrq [NUM_CORES];
  logic                 unusedWdata;

  assign wSrc        = stb.wdata[NUM_SRC-1:0];
  assign wCore       = stb.wdata[NUM_CORES-1:0];
  assign unusedWdata = ^stb.wdata;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enMask   <= '1;
      asgMask  <= '0;
      stallReg <= ~NUM_CORES'(1);
      ctrlReg  <= '0;
      for (int s = 0; s < NUM_SRC; s++) routeReg[s] <= NUM_CORES'(1);
    end else begin
      if (stb.enClr)   enMask  <= enMask & ~wSrc;
      if (stb.enSet)   enMask  <= enMask | wSrc;
      if (stb.asgClr)  asgMask <= asgMask & ~wSrc;
      if (stb.asgSet)  asgMask <= asgMask | wSrc;
      if (stb.stallWr) stallReg <= wCore;
      for (int c = 0; c < NUM_CORES; c++)
        if (stb.ctrlWr && stb.coreIdx == IDX_W'(c)) ctrlReg[c] <= stb.wdata[0];
      for (int s = 0; s < NUM_SRC; s++)
        if (stb.wrRoute && stb.routeIdx == IDX_W'(s)) routeReg[s] <= wCore;
    end
  end

  // source 0 has no physical line
  assign srcLive = ({extLevel, 1'b0} & enMask) | asgMask;

  always_comb begin
    for (int c = 0; c < NUM_CORES; c++) begin
      nextIrq[c] = IRQ_W'(ipiVec[c*3 +: 3]);
      for (int s = 0; s < NUM_SRC; s++)
        if (srcLive[s] && routeReg[s][c]) nextIrq[c][s+2] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    for (int c = 0; c < NUM_CORES; c++)
      irqReg[c] <= rstN ? nextIrq[c] : '0;
  end

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_out
    assign coreIrq[c*IRQ_W +: IRQ_W] = irqReg[c];
  end
  assign coreStall = stallReg;

  always_comb begin
    rdWord = '0;
    case (stb.rdSel)
      RD_ROUTE:
        for (int s = 0; s < NUM_SRC; s++)
          if (stb.routeIdx == IDX_W'(s)) rdWord = DATA_W'(routeReg[s]);
      RD_EN:    rdWord = DATA_W'(enMask);
      RD_ASG:   rdWord = DATA_W'(asgMask);
      RD_IDENT: rdWord = (DATA_W'(NUM_CORES - 1) << 18) | DATA_W'(stb.coreIdx);
      RD_STALL: rdWord = DATA_W'(stallReg);
      RD_CTRL:
        for (int c = 0; c < NUM_CORES; c++)
          if (stb.coreIdx == IDX_W'(c)) rdWord = DATA_W'(ctrlReg[c]);
      default:  rdWord = '0;
    endcase
  end

  // R2 / R3: write-one set and clear
  p_en_clear_r2: assert property (@(posedge clk) disable iff (!rstN)
    stb.enClr |=> (enMask & $past(wSrc)) == '0);
  p_en_set_r2: assert property (@(posedge clk) disable iff (!rstN)
    stb.enSet |=> (enMask & $past(wSrc)) == $past(wSrc));
  p_asg_clear_r3: assert property (@(posedge clk) disable iff (!rstN)
    stb.asgClr |=> (asgMask & $past(wSrc)) == '0);
  p_asg_set_r3: assert property (@(posedge clk) disable iff (!rstN)
    stb.asgSet |=> (asgMask & $past(wSrc)) == $past(wSrc));
  // R8: stall output follows the written word
  p_stall_write_r8: assert property (@(posedge clk) disable iff (!rstN)
    stb.stallWr |=> coreStall == $past(wCore));

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_chk_src
    // R1: routing word stores the written core mask
    p_route_write_r1: assert property (@(posedge clk) disable iff (!rstN)
      (stb.wrRoute && stb.routeIdx == IDX_W'(s)) |=> routeReg[s] == $past(wCore));
    for (genvar c = 0; c < NUM_CORES; c++) begin : g_chk_core
      // R5: asserted source reaches its core regardless of enable
      p_asg_bypass_r5: assert property (@(posedge clk) disable iff (!rstN)
        (asgMask[s] && routeReg[s][c]) |=> coreIrq[c*IRQ_W + s + 2]);
    end
  end

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_chk_ctrl
    // R9: only bit 0 of the data is kept, only for the writer
    p_ctrl_bit0_r9: assert property (@(posedge clk) disable iff (!rstN)
      (stb.ctrlWr && stb.coreIdx == IDX_W'(c)) |=> ctrlReg[c] == $past(stb.wdata[0]));
  end
endmodule

// File: rtl/irq_distributor.sv
module irq_distributor
  import irqd_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int NUM_LINES = 7
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  logic [NUM_LINES-1:0]                 extLevel,
  input  logic [NUM_CORES*3-1:0]               ipiVec,
  input  logic [NUM_CORES-1:0]                 busReq,
  input  logic [NUM_CORES-1:0]                 busWe,
  input  logic [NUM_CORES*10-1:0]              busAddr,
  input  logic [NUM_CORES*32-1:0]              busWdata,
  output logic [NUM_CORES-1:0]                 busAck,
  output logic [31:0]                          busRdata,
  output logic [NUM_CORES*(NUM_LINES+3)-1:0]   coreIrq,
  output logic [NUM_CORES-1:0]                 coreStall
);
  localparam int NUM_SRC = NUM_LINES + 1;

  strobes_t stb;

  irqd_ctrl #(.NUM_CORES(NUM_CORES), .NUM_SRC(NUM_SRC)) u_ctrl (
    .clk(clk), .rstN(rstN), .busReq(busReq), .busWe(busWe),
    .busAddr(busAddr), .busWdata(busWdata), .busAck(busAck), .stb(stb)
  );

  irqd_datapath #(.NUM_CORES(NUM_CORES), .NUM_LINES(NUM_LINES)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .extLevel(extLevel), .ipiVec(ipiVec),
    .rdWord(busRdata), .coreIrq(coreIrq), .coreStall(coreStall)
  );
endmodule

// File: tb/irq_distributor_tb.sv
module irq_distributor_tb;
  localparam int PERIOD = 10;
  localparam int NC = 4;
  localparam int NL = 7;
  localparam int NS = NL + 1;
  localparam int IW = NS + 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NL-1:0]    extLevel = '0;
  logic [2:0]       ipiArr [NC];
  logic [NC-1:0]    req = '0, we = '0;
  logic [9:0]       addrArr [NC];
  logic [31:0]      wdArr [NC];
  logic [NC*3-1:0]  ipiVec;
  logic [NC*10-1:0] busAddr;
  logic [NC*32-1:0] busWdata;
  logic [NC-1:0]    busAck, coreStall;
  logic [31:0]      busRdata;
  logic [NC*IW-1:0] coreIrq;

  always #(PERIOD/2) clk = ~clk;

  always_comb begin
    for (int c = 0; c < NC; c++) begin
      ipiVec[c*3 +: 3]    = ipiArr[c];
      busAddr[c*10 +: 10] = addrArr[c];
      busWdata[c*32 +: 32] = wdArr[c];
    end
  end

  irq_distributor #(.NUM_CORES(NC), .NUM_LINES(NL)) u_dut (
    .clk(clk), .rstN(rstN), .extLevel(extLevel), .ipiVec(ipiVec),
    .busReq(req), .busWe(we), .busAddr(busAddr), .busWdata(busWdata),
    .busAck(busAck), .busRdata(busRdata), .coreIrq(coreIrq), .coreStall(coreStall)
  );

  // behavioural reference state
  logic [NC-1:0] mRoute [NS];
  logic [NS-1:0] mEn, mAsg;
  logic [NC-1:0] mStall, mCtrl;
  logic [IW-1:0] mIrq [NC];

  int checks = 0, errors = 0;
  bit done = 0;
  string curTag = "R0";
  logic [31:0] lastRd;
  logic [NC-1:0] lastAck;

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", curTag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] modelRead(int g, logic [9:0] a);
    if (a < NS) return 32'(mRoute[a]);
    case (a)
      10'h180: return 32'(mEn);
      10'h188: return 32'(mAsg);
      10'h1A0: return (32'(NC - 1) << 18) | 32'(g);
      10'h200: return 32'(mStall);
      10'h220: return 32'(mCtrl[g]);
      default: return 32'h0;
    endcase
  endfunction

  task automatic modelWrite(int g, logic [9:0] a, logic [31:0] d);
    if (a < NS) mRoute[a] = d[NC-1:0];
    else case (a)
      10'h180: mEn  = mEn & ~d[NS-1:0];
      10'h184: mEn  = mEn | d[NS-1:0];
      10'h188: mAsg = mAsg & ~d[NS-1:0];
      10'h18C: mAsg = mAsg | d[NS-1:0];
      10'h200: mStall = d[NC-1:0];
      10'h220: mCtrl[g] = d[0];
      default: ;
    endcase
  endtask

  function automatic logic [IW-1:0] expIrqFor(int c);
    logic [IW-1:0] v;
    v = IW'(ipiArr[c]);
    for (int s = 0; s < NS; s++) begin
      bit live;
      live = (s > 0 && extLevel[s-1] && mEn[s]) || mAsg[s];
      if (live && mRoute[s][c]) v[s+2] = 1'b1;
    end
    return v;
  endfunction

  function automatic logic [IW-1:0] irqOf(int c);
    return coreIrq[c*IW +: IW];
  endfunction

  // one clock: check grant and read data mid-cycle, then compare outputs after the edge
  task automatic step();
    int g;
    logic [IW-1:0] nxt [NC];
    #(PERIOD/4);
    g = -1;
    for (int c = NC - 1; c >= 0; c--) if (req[c]) g = c;
    lastAck = busAck;
    chk("busAck (R11)", 32'(busAck), (g >= 0) ? (32'd1 << g) : 32'd0);
    if (g >= 0 && !we[g]) begin
      lastRd = busRdata;
      chk("read data (R12)", busRdata, modelRead(g, addrArr[g]));
    end
    for (int c = 0; c < NC; c++) nxt[c] = expIrqFor(c);
    @(posedge clk);
    #1;
    if (g >= 0) begin
      if (we[g]) modelWrite(g, addrArr[g], wdArr[g]);
      req[g] = 1'b0;
    end
    for (int c = 0; c < NC; c++) begin
      mIrq[c] = nxt[c];
      chk($sformatf("coreIrq[%0d] (R4)", c), 32'(irqOf(c)), 32'(mIrq[c]));
    end
    chk("coreStall (R8)", 32'(coreStall), 32'(mStall));
  endtask

  task automatic acc(int c, bit w, logic [9:0] a, logic [31:0] d);
    req[c] = 1'b1; we[c] = w; addrArr[c] = a; wdArr[c] = d;
    step();
  endtask

  task automatic rdExp(int c, logic [9:0] a, logic [31:0] exp, string what);
    acc(c, 1'b0, a, 32'h0);
    chk(what, lastRd, exp);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog (all requirements): actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < NC; c++) begin
      ipiArr[c] = '0; addrArr[c] = '0; wdArr[c] = '0; mIrq[c] = '0;
    end
    for (int s = 0; s < NS; s++) mRoute[s] = NC'(1);
    mEn = '1; mAsg = '0; mStall = ~NC'(1); mCtrl = '0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    curTag = "R8";
    chk("reset stall", 32'(coreStall), 32'hE);
    curTag = "R4";
    chk("reset irq", 32'(coreIrq), 32'h0);

    // reset values
    curTag = "R1";
    for (int s = 0; s < NS; s++) rdExp(0, 10'(s), 32'h1, "reset route");
    curTag = "R2";  rdExp(1, 10'h180, 32'hFF, "reset enable");
    curTag = "R3";  rdExp(2, 10'h188, 32'h0, "reset assert");
    curTag = "R7";  rdExp(2, 10'h1A0, 32'h000C0002, "ident core2");
    rdExp(0, 10'h1A0, 32'h000C0000, "ident core0");
    curTag = "R8";  rdExp(3, 10'h200, 32'hE, "reset stall read");
    curTag = "R9";  rdExp(1, 10'h220, 32'h0, "reset ctrl");
    curTag = "R10";
    rdExp(0, 10'h184, 32'h0, "read enable-set offset");
    rdExp(0, 10'h18C, 32'h0, "read assert-set offset");
    rdExp(0, 10'h100, 32'h0, "read unmapped");

    // R4: levels on sources 1 and 3 reach core 0
    curTag = "R4";
    extLevel = 7'b0000101;
    step(); step();
    chk("core0 lines 1,3", 32'(irqOf(0)), 32'h28);
    chk("core1 quiet", 32'(irqOf(1)), 32'h0);

    // R2: clear enable of source 3, then set it again
    curTag = "R2";
    acc(1, 1'b1, 10'h180, 32'h08);
    step();
    chk("source 3 masked", 32'(irqOf(0)), 32'h08);
    rdExp(0, 10'h180, 32'hF7, "enable after clear");
    acc(2, 1'b1, 10'h184, 32'h08);
    rdExp(0, 10'h180, 32'hFF, "enable after set");

    // R1: route source 3 to cores 1 and 2
    curTag = "R1";
    acc(0, 1'b1, 10'h003, 32'hFFFF_FFF6);
    step();
    chk("core0 keeps source1", 32'(irqOf(0)), 32'h08);
    chk("core1 gets source3", 32'(irqOf(1)), 32'h20);
    chk("core2 gets source3", 32'(irqOf(2)), 32'h20);
    rdExp(3, 10'h003, 32'h6, "route readback");

    // R5: assert bypasses a cleared enable
    curTag = "R5";
    acc(0, 1'b1, 10'h180, 32'hFF);
    acc(0, 1'b1, 10'h18C, 32'h20);
    step();
    chk("asserted source5 with enable off", 32'(irqOf(0)), 32'h80);
    chk("core1 all disabled", 32'(irqOf(1)), 32'h0);
    curTag = "R3";
    rdExp(1, 10'h188, 32'h20, "assert readback");
    acc(1, 1'b1, 10'h188, 32'h20);
    step();
    chk("assert cleared", 32'(irqOf(0)), 32'h0);
    acc(1, 1'b1, 10'h184, 32'hFF);

    // R6: source 0 only by software, shares bit 2 with ipi bit 2
    curTag = "R6";
    extLevel = '1;
    step(); step();
    chk("lines never raise source0", 32'(irqOf(0)), 32'h3D8);
    extLevel = '0;
    acc(0, 1'b1, 10'h18C, 32'h01);
    step();
    chk("source0 asserted", 32'(irqOf(0)), 32'h04);
    ipiArr[0] = 3'b100; step(); step();
    chk("ipi2 overlaps source0", 32'(irqOf(0)), 32'h04);
    ipiArr[0] = 3'b011; step(); step();
    chk("ipi plus source0", 32'(irqOf(0)), 32'h07);
    acc(0, 1'b1, 10'h188, 32'h01);
    ipiArr[3] = 3'b101; step(); step();
    chk("ipi only core3", 32'(irqOf(3)), 32'h05);
    chk("core0 ipi only", 32'(irqOf(0)), 32'h03);

    // R8: run-stall write
    curTag = "R8";
    acc(3, 1'b1, 10'h200, 32'hFFFF_FFF5);
    chk("stall after write", 32'(coreStall), 32'h5);
    rdExp(1, 10'h200, 32'h5, "stall readback");

    // R9: per-core flag, bit 0 only
    curTag = "R9";
    acc(1, 1'b1, 10'h220, 32'hFFFF);
    rdExp(1, 10'h220, 32'h1, "ctrl core1 set");
    rdExp(0, 10'h220, 32'h0, "ctrl core0 untouched");
    acc(1, 1'b1, 10'h220, 32'h2);
    rdExp(1, 10'h220, 32'h0, "ctrl keeps bit0 only");

    // R10: writes to unmapped or missing routing offsets
    curTag = "R10";
    acc(2, 1'b1, 10'h008, 32'hF);
    rdExp(2, 10'h008, 32'h0, "route beyond count reads zero");
    acc(2, 1'b1, 10'h1F0, 32'hFFFF_FFFF);
    acc(2, 1'b1, 10'h1A0, 32'hFFFF_FFFF);
    acc(2, 1'b1, 10'h140, 32'hFFFF_FFFF);
    rdExp(0, 10'h180, 32'hFF, "enable unchanged");
    rdExp(0, 10'h188, 32'h0, "assert unchanged");
    rdExp(0, 10'h000, 32'h1, "route0 unchanged");
    rdExp(0, 10'h200, 32'h5, "stall unchanged");
    curTag = "R7";
    rdExp(3, 10'h1A0, 32'h000C0003, "ident ignores writes");

    // R11: simultaneous writes from cores 1 and 3
    curTag = "R11";
    req[1] = 1'b1; we[1] = 1'b1; addrArr[1] = 10'h002; wdArr[1] = 32'h2;
    req[3] = 1'b1; we[3] = 1'b1; addrArr[3] = 10'h002; wdArr[3] = 32'h8;
    step();
    chk("lower core granted first", 32'(lastAck), 32'h2);
    step();
    chk("waiting core granted next", 32'(lastAck), 32'h8);
    rdExp(0, 10'h002, 32'h8, "last writer wins");

    // mixed random traffic, compared every clock
    curTag = "R12";
    for (int i = 0; i < 600; i++) begin
      extLevel = NL'($urandom);
      for (int c = 0; c < NC; c++) ipiArr[c] = 3'($urandom);
      for (int c = 0; c < NC; c++) begin
        if (!req[c] && ($urandom % 4) == 0) begin
          logic [9:0] a;
          case ($urandom % 9)
            0: a = 10'h180; 1: a = 10'h184; 2: a = 10'h188; 3: a = 10'h18C;
            4: a = 10'h200; 5: a = 10'h220; 6: a = 10'h1A0;
            default: a = 10'($urandom % (NS + 2));
          endcase
          req[c] = 1'b1; we[c] = 1'($urandom); addrArr[c] = a; wdArr[c] = $urandom;
        end
      end
      step();
    end
    req = '0;
    step();

    done = 1;
    summary();
    $finish;
  end
endmodule